// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal request port and an external asynchronous static RAM of 32768 bytes. The requester offers one command at a time (read or write, a 15-bit address and, for writes, a byte) with a valid/ready handshake. The controller then drives the memory's active-low select, output-enable and write-strobe pins, its address pins and a shared bidirectional data bus. Each read returns its byte to the requester as a single-cycle pulse.

Every timing minimum of the memory is given as a nanosecond parameter. The controller converts each one to whole clock cycles by rounding up, with at least one cycle per phase. A write runs as a setup phase, then a strobe phase, then a hold phase, with output enable kept inactive throughout. A read runs as an access phase and then an output-hold phase. Between commands the select pin is high, so the memory sits in low-power standby. After reset the controller waits out a recovery interval before it accepts the first command.

Top module: `sram_port_ctl`

## Requirements
- R1: From reset, mem_ce_n, mem_oe_n and mem_we_n are high and req_ready stays low for the recovery interval. At the defaults (20 ns, 5 ns clock) this is 4 clock edges after reset release, after which req_ready goes high.
- R2: While no command is in progress, mem_ce_n is high, req_ready is high and the controller does not drive mem_dq.
- R3: An accepted write gives 1 cycle with mem_ce_n low and mem_we_n high, then 3 cycles with mem_we_n low, then 1 hold cycle with mem_we_n high and mem_ce_n still low. mem_oe_n is high throughout, and mem_addr equals the requested address while mem_ce_n is low.
- R4: The controller drives mem_dq with the write byte from the first cycle of mem_we_n low through the hold cycle. It does not drive mem_dq at any other time, and never while mem_oe_n is low.
- R5: An accepted read holds mem_ce_n and mem_oe_n low and mem_we_n high for 4 access cycles plus 1 output-hold cycle, with mem_addr steady at the requested address.
- R6: rd_valid is a single-cycle pulse in the output-hold cycle of each read, and it never occurs for a write.
- R7: A command is accepted only on a clock edge where req_valid and req_ready are both high. req_ready is low from acceptance until the sequence ends, and a request held while the controller is busy has no effect until req_ready returns.
- R8: rd_data carries the byte present on mem_dq at the end of the access phase. A read therefore returns the byte last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller can take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte returned this cycle |
| rd_data | output | 8 | Returned read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The hardest case to reach from the ports is a sampling instant that is off by one cycle. A controller that latches read data one edge early behaves the same as a correct one against an ideal memory. The bench memory model therefore puts the inverted byte on the bus until the select and output-enable pins have been low for the full access time. Commands are also queued back to back while the controller is busy, so a write is followed at once by a read of the same address. This exercises the hold-to-ignore behaviour of the handshake and the write-then-read data path.

// File: rtl/sram_port_ctl.sv
module sram_port_ctl #(
  parameter int CLK_PERIOD_NS    = 5,
  parameter int T_ADDR_SETUP_NS  = 0,
  parameter int T_WRITE_PULSE_NS = 15,
  parameter int T_DATA_SETUP_NS  = 10,
  parameter int T_ADDR_HOLD_NS   = 2,
  parameter int T_WRITE_CYCLE_NS = 20,
  parameter int T_ACCESS_NS      = 20,
  parameter int T_OUT_HOLD_NS    = 2,
  parameter int T_READ_CYCLE_NS  = 20,
  parameter int T_RECOVER_NS     = 20,
  parameter int AW               = 15,
  parameter int DW               = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_AS  = cyc(T_ADDR_SETUP_NS);
  localparam int N_WP  = max2(cyc(T_WRITE_PULSE_NS), cyc(T_DATA_SETUP_NS));
  localparam int N_AH  = max2(cyc(T_ADDR_HOLD_NS), cyc(T_WRITE_CYCLE_NS) - N_AS - N_WP);
  localparam int N_AA  = cyc(T_ACCESS_NS);
  localparam int N_OH  = max2(cyc(T_OUT_HOLD_NS), cyc(T_READ_CYCLE_NS) - N_AA);
  localparam int N_REC = cyc(T_RECOVER_NS);
  localparam int CW    = 16;

  typedef enum logic [2:0] {S_REC, S_IDLE, S_WSU, S_WPL, S_WHD, S_RAC, S_RHD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wdata_q;
  logic          dq_en;

  assign req_ready = (st == S_IDLE);
  assign mem_ce_n  = (st == S_REC) || (st == S_IDLE);
  assign mem_we_n  = (st != S_WPL);
  assign mem_oe_n  = !((st == S_RAC) || (st == S_RHD));
  assign dq_en     = (st == S_WPL) || (st == S_WHD);
  assign mem_dq    = dq_en ? wdata_q : {DW{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_REC;
      cnt      <= CW'(N_REC - 1);
      rd_valid <= 1'b0;
      rd_data  <= '0;
      mem_addr <= '0;
      wdata_q  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          mem_addr <= req_addr;
          wdata_q  <= req_wdata;
          if (req_write) begin
            st  <= S_WSU;
            cnt <= CW'(N_AS - 1);
          end else begin
            st  <= S_RAC;
            cnt <= CW'(N_AA - 1);
          end
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_WSU: begin st <= S_WPL; cnt <= CW'(N_WP - 1); end
          S_WPL: begin st <= S_WHD; cnt <= CW'(N_AH - 1); end
          S_RAC: begin
            st       <= S_RHD;
            cnt      <= CW'(N_OH - 1);
            rd_data  <= mem_dq;
            rd_valid <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module sram_port_ctl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          dq_en
);

  // R3
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> mem_oe_n);

  // R4
  strobe_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> dq_en);

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !dq_en));

  // R5
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_port_ctl sram_port_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .dq_en(dq_en)
);

// File: tb/sim_sram_port_ctl.sv
module sim_sram_port_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  wire  [7:0]  mem_dq;

  always #2.5 clk = ~clk;

  sram_port_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [7:0] init_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  // external memory model: data is wrong until 4 cycles of access have elapsed
  logic [7:0] sram [int];
  int         acc_cnt = 0;
  logic [7:0] sram_q;
  logic       sram_drv;
  assign sram_drv = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
  always_comb begin
    sram_q = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : init_byte(mem_addr);
    if (acc_cnt < 3) sram_q = ~sram_q;
  end
  assign mem_dq = sram_drv ? sram_q : 8'bz;
  always @(posedge clk) acc_cnt <= sram_drv ? acc_cnt + 1 : 0;
  always @(posedge mem_we_n) if (rst_n && !mem_ce_n) sram[int'(mem_addr)] = mem_dq;

  // reference model
  typedef struct packed {
    logic ce_n, oe_n, we_n, drv, rv;
    logic [14:0] a;
    logic [7:0]  d;
  } exp_t;
  exp_t       q[$];
  logic [7:0] shadow [int];
  int         rec = 4;

  always @(posedge clk) begin
    bit was_ready;
    if (!rst_n) begin
      q.delete();
      rec = 4;
    end else begin
      was_ready = (rec == 0) && (q.size() == 0);
      if (q.size() != 0) void'(q.pop_front());
      if (rec > 0) rec--;
      if (was_ready && req_valid) begin
        if (req_write) begin
          q.push_back('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, req_addr, req_wdata});
          for (int i = 0; i < 3; i++)
            q.push_back('{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, req_addr, req_wdata});
          q.push_back('{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, req_addr, req_wdata});
          shadow[int'(req_addr)] = req_wdata;
        end else begin
          for (int i = 0; i < 4; i++)
            q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, req_addr, 8'h00});
          q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, req_addr,
                        shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : init_byte(req_addr)});
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    logic er;
    if (!done) begin
      e  = (q.size() != 0) ? q[0] : '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 15'h0, 8'h0};
      er = rst_n && (rec == 0) && (q.size() == 0);
      if (!rst_n || rec > 0) begin
        chk(!req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R1 reset/recovery pins",
            {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'b0111);
      end else begin
        chk(req_ready == er, "R7 req_ready", req_ready, er);
        chk(mem_ce_n == e.ce_n, "R2 mem_ce_n", mem_ce_n, e.ce_n);
        chk(mem_we_n == e.we_n, "R3 mem_we_n", mem_we_n, e.we_n);
        chk(mem_oe_n == e.oe_n, "R5 mem_oe_n", mem_oe_n, e.oe_n);
        if (!e.ce_n) chk(mem_addr == e.a, "R3 mem_addr", mem_addr, e.a);
        if (e.drv) chk(mem_dq == e.d, "R4 mem_dq", mem_dq, e.d);
        chk(rd_valid == e.rv, "R6 rd_valid", rd_valid, e.rv);
        if (e.rv) chk(rd_data == e.d, "R8 rd_data", rd_data, e.d);
      end
    end
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0011; req_wdata = 8'h99;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    issue(1'b1, 15'h0000, 8'h00);
    issue(1'b1, 15'h7FFF, 8'hFF);
    issue(1'b1, 15'h1234, 8'hA5);
    issue(1'b0, 15'h1234, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h4321, 8'h00);
    repeat (3) @(negedge clk);
    issue(1'b1, 15'h1234, 8'h5A);
    issue(1'b0, 15'h1234, 8'h00);
    issue(1'b1, 15'h1235, 8'hC3);
    issue(1'b0, 15'h1234, 8'h00);
    for (int i = 0; i < 12; i++) issue(i[0], 15'(i * 977), 8'(i * 37 + 1));
    for (int i = 0; i < 12; i++) issue(1'b0, 15'(i * 977), 8'h00);
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule